// File: doc/BRIEF.md
# CAN Error State and Interrupt Tracker

This block sits beside a CAN protocol engine and turns its raw error bookkeeping into a register view for software. Every cycle it samples the engine's transmit and receive error counter values and resolves them into a single fault-confinement state: error-active, warning, error-passive or bus-off. It also latches one-cycle frame-error pulses (CRC, stuffing, acknowledge, form and bit error) into sticky flags. It mirrors per-mailbox and auxiliary event levels into the same 32-bit status word.

Software reads the status word through a simple strobe-based register port. A status read clears the frame-error flags but leaves the state bits alone. The interrupt mask cannot be written directly. It is changed only through a set-port and a clear-port, and it reads back at its own address. The interrupt line is high whenever any status bit is set under a set mask bit. Counting the error events and sequencing recovery from bus-off are left to the protocol engine.

Register addresses (3-bit word index): 0 status, 1 mask, 2 mask-set (write only), 3 mask-clear (write only), 4 error counters. Any other address, and the write-only ones, reads as zero.

Top module: `can_err_irq_tracker`

## Requirements
- R1: After reset, the mask reads 0, no frame-error flag is set, the error-active state bit (16) is the only state bit set when both counters are 0, and irq_o is low.
- R2: Status bits 19:16 are one-hot (16 active, 17 warning, 18 passive, 19 bus-off). The priority order is bus-off over passive over warning over active.
- R3: Warning is reported when either counter is 96 or more. Passive is reported when either counter exceeds 127. Bus-off is reported when the transmit counter exceeds 255. Each takes effect one clock after the counter values are presented.
- R4: The error counter register holds the receive count in bits 7:0 and the low eight transmit bits in bits 23:16. Bit 24 holds the ninth transmit bit, and all other bits are 0.
- R5: A pulse on ferr_evt_i bit k sets status bit 24+k and holds it (k = 0 CRC, 1 stuffing, 2 acknowledge, 3 form, 4 bit error).
- R6: A read of the status address returns the flags and then clears them. The state, mailbox and auxiliary bits are not cleared by the read.
- R7: A frame-error pulse that arrives in the same cycle as a status read is still set after that read.
- R8: A write to the mask-set address ORs the written ones into the mask. A write to the mask-clear address removes them. All other mask bits keep their value, and the mask address reads back the current mask.
- R9: irq_o is the OR of all status bits ANDed with the mask.
- R10: Status bits 15:0 mirror mbx_evt_i and bits 23:20 mirror aux_evt_i, one clock late. Bits 31:29 read 0.
- R11: Reads of addresses other than status do not clear flags. Writes to the status and counter addresses change neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| tec_i | input | TEC_W (9) | Transmit error counter from the protocol engine |
| rec_i | input | REC_W (8) | Receive error counter from the protocol engine |
| ferr_evt_i | input | 5 | One-cycle frame-error pulses |
| mbx_evt_i | input | 16 | Per-mailbox event levels |
| aux_evt_i | input | 4 | Sleep, wakeup, timer overflow, timestamp levels |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a frame-error pulse that collides with the clear-on-read of the status word. The stimulus raises the pulse and the read strobe on the same falling edge. It then expects the colliding read to show the flag still clear, and the following read to show it set. The threshold edges (95/96, 127/128, 255/256) are stepped one value at a time, and the priority is checked with both counters high at once.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
    localparam int STAT_W     = 32;
    localparam int NUM_MBX    = 16;
    localparam int NUM_STATE  = 4;
    localparam int NUM_AUX    = 4;
    localparam int NUM_FERR   = 5;
    localparam int MBX_LO     = 0;
    localparam int STATE_LO   = 16;
    localparam int AUX_LO     = 20;
    localparam int FERR_LO    = 24;
    localparam int ADDR_W     = 3;

    // one-hot state indices inside the state field
    localparam int ST_ACTIVE  = 0;
    localparam int ST_WARN    = 1;
    localparam int ST_PASSIVE = 2;
    localparam int ST_BOFF    = 3;

    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK    = 3'd1;
    localparam logic [ADDR_W-1:0] A_MSET    = 3'd2;
    localparam logic [ADDR_W-1:0] A_MCLR    = 3'd3;
    localparam logic [ADDR_W-1:0] A_ERRCNT  = 3'd4;

    localparam int ECR_REC_LO = 0;
    localparam int ECR_TEC_LO = 16;
endpackage

// File: rtl/can_fc_resolve.sv
module can_fc_resolve
    import can_err_pkg::*;
#(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int BOFF_LIM    = 255
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [TEC_W-1:0]     tec_i,
    input  logic [REC_W-1:0]     rec_i,
    output logic [NUM_STATE-1:0] state_o,
    output logic [TEC_W-1:0]     tec_o,
    output logic [REC_W-1:0]     rec_o
);
    typedef struct packed {
        logic [NUM_STATE-1:0] state;
        logic [TEC_W-1:0]     tec;
        logic [REC_W-1:0]     rec;
    } fc_t;

    fc_t fc_d, fc_q;

    logic over_boff, over_pass, over_warn;

    always_comb begin
        over_boff = 32'(tec_i) > 32'(BOFF_LIM);
        over_pass = (32'(tec_i) > 32'(PASSIVE_LIM)) || (32'(rec_i) > 32'(PASSIVE_LIM));
        over_warn = (32'(tec_i) >= 32'(WARN_LIM)) || (32'(rec_i) >= 32'(WARN_LIM));
        fc_d       = fc_q;
        fc_d.tec   = tec_i;
        fc_d.rec   = rec_i;
        fc_d.state = '0;
        if (over_boff)      fc_d.state[ST_BOFF]    = 1'b1;
        else if (over_pass) fc_d.state[ST_PASSIVE] = 1'b1;
        else if (over_warn) fc_d.state[ST_WARN]    = 1'b1;
        else                fc_d.state[ST_ACTIVE]  = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fc_q       <= '0;
            fc_q.state <= NUM_STATE'(1) << ST_ACTIVE;
        end else begin
            fc_q <= fc_d;
        end
    end

    assign state_o = fc_q.state;
    assign tec_o   = fc_q.tec;
    assign rec_o   = fc_q.rec;

    // R2
    state_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(fc_q.state) == 1);

    // R3
    boff_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(tec_i) > 32'(BOFF_LIM)) |=> fc_q.state[ST_BOFF]);

    // R3
    pass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((32'(rec_i) > 32'(PASSIVE_LIM)) && (32'(tec_i) <= 32'(BOFF_LIM)))
        |=> fc_q.state[ST_PASSIVE]);
endmodule

// File: rtl/can_ferr_flags.sv
module can_ferr_flags #(
    parameter int N = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        for (int k = 0; k < N; k++) begin
            if (evt_i[k])      fl_d.flags[k] = 1'b1;
            else if (clr_i)    fl_d.flags[k] = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= '0;
        else         fl_q <= fl_d;
    end

    assign flags_o = fl_q.flags;

    // R7
    evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((fl_q.flags & $past(evt_i)) == $past(evt_i)));

    // R6
    clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && evt_i == '0) |=> (fl_q.flags == '0));

    // R5
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i) |=> ((fl_q.flags & $past(fl_q.flags)) == $past(fl_q.flags)));
endmodule

// File: rtl/can_irq_mask.sv
module can_irq_mask #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mk_t;

    mk_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (set_i)      mk_d.mask = mk_q.mask | wdata_i;
        else if (clr_i) mk_d.mask = mk_q.mask & ~wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mk_q <= '0;
        else         mk_q <= mk_d;
    end

    assign mask_o = mk_q.mask;

    // R8
    set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> ((mk_q.mask & $past(wdata_i)) == $past(wdata_i)));

    // R8
    clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> ((mk_q.mask & $past(wdata_i)) == '0));

    // R11
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i && !clr_i) |=> $stable(mk_q.mask));
endmodule

// File: rtl/can_err_irq_tracker.sv
module can_err_irq_tracker
    import can_err_pkg::*;
#(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int BOFF_LIM    = 255
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [TEC_W-1:0]      tec_i,
    input  logic [REC_W-1:0]      rec_i,
    input  logic [NUM_FERR-1:0]   ferr_evt_i,
    input  logic [NUM_MBX-1:0]    mbx_evt_i,
    input  logic [NUM_AUX-1:0]    aux_evt_i,
    input  logic                  reg_rd_i,
    input  logic                  reg_wr_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [STAT_W-1:0]     reg_wdata_i,
    output logic [STAT_W-1:0]     reg_rdata_o,
    output logic                  irq_o
);
    typedef struct packed {
        logic [NUM_MBX-1:0] mbx;
        logic [NUM_AUX-1:0] aux;
    } lv_t;

    lv_t lv_d, lv_q;

    logic [NUM_STATE-1:0] state;
    logic [TEC_W-1:0]     tec_q;
    logic [REC_W-1:0]     rec_q;
    logic [NUM_FERR-1:0]  flags;
    logic [STAT_W-1:0]    mask;
    logic [STAT_W-1:0]    status;
    logic [STAT_W-1:0]    errcnt;
    logic                 rd_status, wr_set, wr_clr;

    can_fc_resolve #(
        .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
        .PASSIVE_LIM(PASSIVE_LIM), .BOFF_LIM(BOFF_LIM)
    ) u_resolve (
        .clk_i(clk_i), .rst_ni(rst_ni), .tec_i(tec_i), .rec_i(rec_i),
        .state_o(state), .tec_o(tec_q), .rec_o(rec_q)
    );

    can_ferr_flags #(.N(NUM_FERR)) u_flags (
        .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(ferr_evt_i),
        .clr_i(rd_status), .flags_o(flags)
    );

    can_irq_mask #(.W(STAT_W)) u_mask (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(wr_set), .clr_i(wr_clr),
        .wdata_i(reg_wdata_i), .mask_o(mask)
    );

    always_comb begin
        lv_d     = lv_q;
        lv_d.mbx = mbx_evt_i;
        lv_d.aux = aux_evt_i;

        rd_status = reg_rd_i && (reg_addr_i == A_STATUS);
        wr_set    = reg_wr_i && (reg_addr_i == A_MSET);
        wr_clr    = reg_wr_i && (reg_addr_i == A_MCLR);

        status = '0;
        status[MBX_LO   +: NUM_MBX]   = lv_q.mbx;
        status[STATE_LO +: NUM_STATE] = state;
        status[AUX_LO   +: NUM_AUX]   = lv_q.aux;
        status[FERR_LO  +: NUM_FERR]  = flags;

        errcnt = '0;
        errcnt[ECR_REC_LO +: REC_W] = rec_q;
        errcnt[ECR_TEC_LO +: TEC_W] = tec_q;

        unique case (reg_addr_i)
            A_STATUS: reg_rdata_o = status;
            A_MASK:   reg_rdata_o = mask;
            A_ERRCNT: reg_rdata_o = errcnt;
            default:  reg_rdata_o = '0;
        endcase

        irq_o = |(status & mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lv_q <= '0;
        else         lv_q <= lv_d;
    end

    // R9
    irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (mask != '0));

    // R10
    mbx_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (status[MBX_LO +: NUM_MBX] == $past(mbx_evt_i)));

    // R6
    state_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_status && $stable(tec_i) && $stable(rec_i))
        |=> (status[STATE_LO +: NUM_STATE] == $past(status[STATE_LO +: NUM_STATE])));
endmodule

// File: tb/can_err_irq_tracker_tb_top.sv
module can_err_irq_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  tec = '0;
    logic [7:0]  rec = '0;
    logic [4:0]  ferr = '0;
    logic [15:0] mbx = '0;
    logic [3:0]  aux = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #2 clk = ~clk;

    can_err_irq_tracker dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tec_i(tec), .rec_i(rec),
        .ferr_evt_i(ferr), .mbx_evt_i(mbx), .aux_evt_i(aux),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct {
        logic [31:0] data;
        bit          chk_irq;
        logic        irq;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] m_mask = '0;

    function automatic logic [3:0] exp_state(input int t, input int r);
        if (t > 255)                  return 4'b1000;
        else if (t > 127 || r > 127)  return 4'b0100;
        else if (t >= 96 || r >= 96)  return 4'b0010;
        else                          return 4'b0001;
    endfunction

    function automatic logic [31:0] st(input logic [3:0] s, input logic [4:0] f,
                                       input logic [15:0] m, input logic [3:0] a);
        return {3'b000, f, a, s, m};
    endfunction

    // monitor: compares each read against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (rdata !== it.data) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.data);
                end
                if (it.chk_irq) begin
                    n_chk++;
                    if (irq !== it.irq) begin
                        n_fail++;
                        $display("FAIL %s: irq actual %b expected %b", it.tag, irq, it.irq);
                    end
                end
            end
        end
    end

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; rd = 1'b1;
        it.data = exp; it.chk_irq = (a == 3'd0); it.irq = |(exp & m_mask); it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        if (a == 3'd2) m_mask = m_mask | d;
        if (a == 3'd3) m_mask = m_mask & ~d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic set_cnt(input int t, input int r);
        @(negedge clk);
        tec = 9'(t); rec = 8'(r);
    endtask

    task automatic pulse(input logic [4:0] f);
        @(negedge clk);
        ferr = f;
        @(negedge clk);
        ferr = '0;
    endtask

    task automatic chk_state(input int t, input int r, input string tag);
        set_cnt(t, r);
        rd_chk(3'd0, st(exp_state(t, r), 5'b0, 16'h0, 4'h0), tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(3'd0, 32'h0001_0000, "R1 status");
        rd_chk(3'd1, 32'h0, "R1 mask");
        @(negedge clk); #1;
        n_chk++;
        if (irq !== 1'b0) begin n_fail++; $display("FAIL R1: irq actual %b expected 0", irq); end

        // R4 error counter layout
        set_cnt(9'h0A5, 8'h3C);
        rd_chk(3'd4, 32'h00A5_003C, "R4 ecr");
        set_cnt(300, 8'h11);
        rd_chk(3'd4, 32'h012C_0011, "R4 ecr ninth bit");

        // R3 thresholds, R2 priority
        chk_state(95, 0, "R3 tec 95");
        chk_state(96, 0, "R3 tec 96");
        chk_state(0, 95, "R3 rec 95");
        chk_state(0, 96, "R3 rec 96");
        chk_state(0, 127, "R3 rec 127");
        chk_state(0, 128, "R3 rec 128");
        chk_state(128, 0, "R3 tec 128");
        chk_state(255, 0, "R3 tec 255");
        chk_state(256, 0, "R3 tec 256");
        chk_state(300, 200, "R2 boff over passive");
        chk_state(100, 200, "R2 passive over warn");
        chk_state(0, 0, "R2 back to active");

        // R5 sticky flags, R6 clear on read
        pulse(5'b00101);
        rd_chk(3'd0, st(4'b0001, 5'b00101, 16'h0, 4'h0), "R5 flags set");
        rd_chk(3'd0, st(4'b0001, 5'b00000, 16'h0, 4'h0), "R6 flags cleared");
        set_cnt(130, 0);
        pulse(5'b10000);
        rd_chk(3'd0, st(4'b0100, 5'b10000, 16'h0, 4'h0), "R5 bit error");
        rd_chk(3'd0, st(4'b0100, 5'b00000, 16'h0, 4'h0), "R6 state kept");
        set_cnt(0, 0);

        // R7 event colliding with read
        @(negedge clk);
        begin
            item_t it;
            ferr = 5'b01000; addr = 3'd0; rd = 1'b1;
            it.data = st(4'b0001, 5'b0, 16'h0, 4'h0); it.chk_irq = 1'b1;
            it.irq = 1'b0; it.tag = "R7 collide read";
            sb.push_back(it);
        end
        @(negedge clk);
        ferr = '0; rd = 1'b0;
        rd_chk(3'd0, st(4'b0001, 5'b01000, 16'h0, 4'h0), "R7 flag survived");

        // R11 other reads do not clear; read-only writes ignored
        pulse(5'b00010);
        rd_chk(3'd1, 32'h0, "R11 mask read");
        rd_chk(3'd4, 32'h0, "R11 ecr read");
        wr_reg(3'd0, 32'hFFFF_FFFF);
        wr_reg(3'd4, 32'hFFFF_FFFF);
        rd_chk(3'd1, 32'h0, "R11 mask untouched");
        rd_chk(3'd0, st(4'b0001, 5'b00010, 16'h0, 4'h0), "R11 flag kept");

        // R8 mask set/clear
        wr_reg(3'd2, 32'h0100_0000);
        rd_chk(3'd1, 32'h0100_0000, "R8 set one");
        wr_reg(3'd2, 32'h0001_0001);
        rd_chk(3'd1, 32'h0101_0001, "R8 set more");
        wr_reg(3'd3, 32'h0100_0000);
        rd_chk(3'd1, 32'h0001_0001, "R8 clear one");
        rd_chk(3'd2, 32'h0, "R8 set port reads zero");

        // R9 irq from state bit under mask
        rd_chk(3'd0, st(4'b0001, 5'b0, 16'h0, 4'h0), "R9 irq active");
        wr_reg(3'd3, 32'h0001_0000);
        rd_chk(3'd0, st(4'b0001, 5'b0, 16'h0, 4'h0), "R9 irq masked");

        // R10 mirrors, R9 via mailbox bit
        @(negedge clk);
        mbx = 16'h8001; aux = 4'b1010;
        rd_chk(3'd0, st(4'b0001, 5'b0, 16'h8001, 4'b1010), "R10 mirror");
        @(negedge clk);
        mbx = 16'h8000;
        rd_chk(3'd0, st(4'b0001, 5'b0, 16'h8000, 4'b1010), "R9 irq drop");
        wr_reg(3'd2, 32'h0080_0000);
        rd_chk(3'd0, st(4'b0001, 5'b0, 16'h8000, 4'b1010), "R9 irq aux");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule